// File: doc/BRIEF.md
# Serial Port Status and Interrupt Controller

This block keeps the status flags of an asynchronous serial port and turns them into three interrupt requests. It watches single-cycle strobes from the receiver and the transmitter, along with level inputs from the line idle detectors. It also watches decoded CPU register accesses: a read of receive data, a write of transmit data, and a write of the control register. The control register write carries an error-clear bit and three interrupt enables.

Each flag has exactly one way to be cleared, and that way is tied to one register access. The transmit-empty flag leaves every reset at 1, so enabling the transmit interrupt fires it immediately. The bus-idle request needs both line directions idle at the same time, and it is held off in synchronous mode. When a set event and a clear access arrive in the same cycle, the set wins. This way no event is lost.

Top module: `usic_status`

## Requirements
- R1: A `rx_done` strobe sets `rx_full` at the next edge. Only a `rd_rdata` strobe clears it. Control writes, error clears and transmit accesses leave it unchanged.
- R2: A `rx_done` strobe with `rx_stop_bit`=0 sets `err_frame`. A `rx_done` strobe with `rx_parity_ok`=0 sets `err_parity`. Both take effect at the next edge.
- R3: A `wr_ctrl` strobe with `wr_err_clr`=1 produces an internal clear pulse that lasts exactly one cycle. That pulse clears `err_frame` and `err_parity` one edge later, which is two edges after the write. The bit is not stored, and `rx_full` is not affected.
- R4: `tx_empty` is 1 after `rst_n` low and after `soft_rst`. A `tx_load` strobe sets it. Only a `wr_tdata` strobe clears it.
- R5: When a set event and that flag's clear land in the same cycle, the flag ends up set.
- R6: `rx_irq` is a registered level. It equals (receive enable AND (`rx_full` OR `err_frame` OR `err_parity`)) as those stood one edge earlier.
- R7: `tx_irq` is a registered level. It equals (transmit enable AND `tx_empty`) one edge earlier. Enabling it after reset therefore raises it without any transmit activity.
- R8: `idle_irq` is 1 one edge after a cycle in which the idle enable, `rx_idle` and `tx_idle` are all 1 and `sync_mode` is 0. Otherwise it is 0.
- R9: `data_valid` is 1 exactly when `rx_full`=1 and both error flags are 0.
- R10: `soft_rst` is synchronous. At the next edge it returns every flag to its reset value, zeroes all enables and the clear pulse, and drops all interrupts. It takes priority over every event.
- R11: The enables `wr_rx_ie`, `wr_tx_ie` and `wr_idle_ie` are captured only on a `wr_ctrl` strobe and are held otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous software reset |
| rx_done | input | 1 | Receiver finished a frame |
| rx_stop_bit | input | 1 | Sampled stop bit value, valid with rx_done |
| rx_parity_ok | input | 1 | Parity check result, valid with rx_done |
| tx_load | input | 1 | Transmit data moved into the empty shift path |
| rx_idle | input | 1 | Receive line idle level |
| tx_idle | input | 1 | Transmit line idle level |
| sync_mode | input | 1 | Port runs synchronously; idle flags invalid |
| rd_rdata | input | 1 | CPU read of receive data |
| wr_tdata | input | 1 | CPU write of transmit data |
| wr_ctrl | input | 1 | CPU write of control bits |
| wr_err_clr | input | 1 | Error-clear bit of the control write |
| wr_rx_ie | input | 1 | Receive interrupt enable of the control write |
| wr_tx_ie | input | 1 | Transmit interrupt enable of the control write |
| wr_idle_ie | input | 1 | Bus-idle interrupt enable of the control write |
| rx_full | output | 1 | Receive data full flag |
| err_frame | output | 1 | Framing error flag |
| err_parity | output | 1 | Parity error flag |
| tx_empty | output | 1 | Transmit data empty flag |
| data_valid | output | 1 | Received data is full and error-free |
| rx_irq | output | 1 | Receive interrupt request |
| tx_irq | output | 1 | Transmit interrupt request |
| idle_irq | output | 1 | Bus-idle interrupt request |

## Verification
Good frames, frames with a bad stop bit and frames with a bad parity are received both with the receive enable off and with it on. This separates flag setting from interrupt gating and shows when `data_valid` drops. Error clears and control writes are issued while `rx_full` is set, which shows that each flag follows only its own clear path. Set and clear accesses are made to collide on every flag to confirm the set-wins order. All four combinations of the idle levels are walked with synchronous mode off and then on. Soft and hardware resets are applied from a busy state to show that `tx_empty` returns to 1.

// File: rtl/usic_pkg.sv
package usic_pkg;
    localparam int unsigned USIC_NUM_IRQ = 3;
    localparam int unsigned IRQ_RX   = 0;
    localparam int unsigned IRQ_TX   = 1;
    localparam int unsigned IRQ_IDLE = 2;

    typedef struct packed {
        logic rx_ie;
        logic tx_ie;
        logic idle_ie;
    } usic_en_t;

    localparam usic_en_t USIC_EN_OFF = '{rx_ie: 1'b0, tx_ie: 1'b0, idle_ie: 1'b0};
endpackage

// File: rtl/usic_flag.sv
module usic_flag #(
    parameter bit RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic set_ev,
    input  logic clr_ev,
    output logic q
);
    // Priority: reset, then set, then clear.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= RESET_VAL;
        else if (soft_rst)
            q <= RESET_VAL;
        else if (set_ev)
            q <= 1'b1;
        else if (clr_ev)
            q <= 1'b0;
    end
endmodule

// File: rtl/usic_ctrl_regs.sv
module usic_ctrl_regs
    import usic_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     soft_rst,
    input  logic     wr_ctrl,
    input  logic     wr_err_clr,
    input  logic     wr_rx_ie,
    input  logic     wr_tx_ie,
    input  logic     wr_idle_ie,
    output usic_en_t en_q,
    output logic     err_clr_pulse
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q          <= USIC_EN_OFF;
            err_clr_pulse <= 1'b0;
        end else if (soft_rst) begin
            en_q          <= USIC_EN_OFF;
            err_clr_pulse <= 1'b0;
        end else begin
            // The clear bit is never stored: it lives for one cycle only.
            err_clr_pulse <= wr_ctrl && wr_err_clr;
            if (wr_ctrl) begin
                en_q.rx_ie   <= wr_rx_ie;
                en_q.tx_ie   <= wr_tx_ie;
                en_q.idle_ie <= wr_idle_ie;
            end
        end
    end
endmodule

// File: rtl/usic_irq_gen.sv
module usic_irq_gen #(
    parameter int unsigned N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_rst,
    input  logic [N-1:0] req,
    output logic [N-1:0] irq
);
    for (genvar i = 0; i < N; i++) begin : g_irq
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                irq[i] <= 1'b0;
            else if (soft_rst)
                irq[i] <= 1'b0;
            else
                irq[i] <= req[i];
        end
    end
endmodule

// File: rtl/usic_status.sv
module usic_status
    import usic_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic rx_done,
    input  logic rx_stop_bit,
    input  logic rx_parity_ok,
    input  logic tx_load,
    input  logic rx_idle,
    input  logic tx_idle,
    input  logic sync_mode,
    input  logic rd_rdata,
    input  logic wr_tdata,
    input  logic wr_ctrl,
    input  logic wr_err_clr,
    input  logic wr_rx_ie,
    input  logic wr_tx_ie,
    input  logic wr_idle_ie,
    output logic rx_full,
    output logic err_frame,
    output logic err_parity,
    output logic tx_empty,
    output logic data_valid,
    output logic rx_irq,
    output logic tx_irq,
    output logic idle_irq
);
    usic_en_t                en_q;
    logic                    err_clr_pulse;
    logic [USIC_NUM_IRQ-1:0] irq_req;
    logic [USIC_NUM_IRQ-1:0] irq_q;

    usic_ctrl_regs u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .soft_rst      (soft_rst),
        .wr_ctrl       (wr_ctrl),
        .wr_err_clr    (wr_err_clr),
        .wr_rx_ie      (wr_rx_ie),
        .wr_tx_ie      (wr_tx_ie),
        .wr_idle_ie    (wr_idle_ie),
        .en_q          (en_q),
        .err_clr_pulse (err_clr_pulse)
    );

    usic_flag #(.RESET_VAL(1'b0)) u_rx_full (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .set_ev(rx_done), .clr_ev(rd_rdata), .q(rx_full)
    );

    usic_flag #(.RESET_VAL(1'b0)) u_err_frame (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .set_ev(rx_done && !rx_stop_bit), .clr_ev(err_clr_pulse), .q(err_frame)
    );

    usic_flag #(.RESET_VAL(1'b0)) u_err_parity (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .set_ev(rx_done && !rx_parity_ok), .clr_ev(err_clr_pulse), .q(err_parity)
    );

    usic_flag #(.RESET_VAL(1'b1)) u_tx_empty (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .set_ev(tx_load), .clr_ev(wr_tdata), .q(tx_empty)
    );

    always_comb begin
        irq_req           = '0;
        irq_req[IRQ_RX]   = en_q.rx_ie && (rx_full || err_frame || err_parity);
        irq_req[IRQ_TX]   = en_q.tx_ie && tx_empty;
        irq_req[IRQ_IDLE] = en_q.idle_ie && rx_idle && tx_idle && !sync_mode;
    end

    usic_irq_gen #(.N(USIC_NUM_IRQ)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .req      (irq_req),
        .irq      (irq_q)
    );

    assign rx_irq     = irq_q[IRQ_RX];
    assign tx_irq     = irq_q[IRQ_TX];
    assign idle_irq   = irq_q[IRQ_IDLE];
    assign data_valid = rx_full && !err_frame && !err_parity;
endmodule

// File: rtl/usic_status_chk.sv
module usic_status_chk (
    input logic clk,
    input logic rst_n,
    input logic soft_rst,
    input logic rx_done,
    input logic rx_stop_bit,
    input logic rd_rdata,
    input logic wr_tdata,
    input logic tx_load,
    input logic sync_mode,
    input logic rx_ie,
    input logic rx_full,
    input logic err_frame,
    input logic err_parity,
    input logic tx_empty,
    input logic rx_irq,
    input logic idle_irq
);
    AST_RXFULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && !rd_rdata && !soft_rst) |=> rx_full); // R1
    AST_FRAME_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && !rx_stop_bit && !soft_rst) |=> err_frame); // R2
    AST_TXEMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_empty && !wr_tdata && !soft_rst) |=> tx_empty); // R4
    AST_TXEMPTY_ONLY_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_empty && !tx_load && !soft_rst) |=> !tx_empty); // R4
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && rd_rdata && !soft_rst) |=> rx_full); // R5
    AST_RXIRQ_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !soft_rst |=> (rx_irq == $past(rx_ie && (rx_full || err_frame || err_parity)))); // R6
    AST_IDLE_SYNC_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        sync_mode |=> !idle_irq); // R8
    AST_SOFT_RST: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (tx_empty && !rx_full && !rx_irq && !idle_irq)); // R10
endmodule

bind usic_status usic_status_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .soft_rst    (soft_rst),
    .rx_done     (rx_done),
    .rx_stop_bit (rx_stop_bit),
    .rd_rdata    (rd_rdata),
    .wr_tdata    (wr_tdata),
    .tx_load     (tx_load),
    .sync_mode   (sync_mode),
    .rx_ie       (en_q.rx_ie),
    .rx_full     (rx_full),
    .err_frame   (err_frame),
    .err_parity  (err_parity),
    .tx_empty    (tx_empty),
    .rx_irq      (rx_irq),
    .idle_irq    (idle_irq)
);

// File: tb/usic_status_test.sv
module usic_status_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic soft_rst = 0, rx_done = 0, rx_stop_bit = 1, rx_parity_ok = 1, tx_load = 0;
    logic rx_idle = 0, tx_idle = 0, sync_mode = 0, rd_rdata = 0, wr_tdata = 0;
    logic wr_ctrl = 0, wr_err_clr = 0, wr_rx_ie = 0, wr_tx_ie = 0, wr_idle_ie = 0;
    logic rx_full, err_frame, err_parity, tx_empty, data_valid, rx_irq, tx_irq, idle_irq;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // behavioural reference state
    bit m_full, m_fre, m_pe, m_temp = 1, m_clr, m_rie, m_tie, m_bie, m_rxi, m_txi, m_idi;

    always #2 clk = ~clk;

    usic_status uut (.*);

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_full <= 0; m_fre <= 0; m_pe <= 0; m_temp <= 1; m_clr <= 0;
            m_rie <= 0; m_tie <= 0; m_bie <= 0; m_rxi <= 0; m_txi <= 0; m_idi <= 0;
        end else if (soft_rst) begin
            m_full <= 0; m_fre <= 0; m_pe <= 0; m_temp <= 1; m_clr <= 0;
            m_rie <= 0; m_tie <= 0; m_bie <= 0; m_rxi <= 0; m_txi <= 0; m_idi <= 0;
        end else begin
            m_clr  <= wr_ctrl & wr_err_clr;
            m_full <= rx_done ? 1'b1 : (rd_rdata ? 1'b0 : m_full);
            m_fre  <= (rx_done & ~rx_stop_bit) ? 1'b1 : (m_clr ? 1'b0 : m_fre);
            m_pe   <= (rx_done & ~rx_parity_ok) ? 1'b1 : (m_clr ? 1'b0 : m_pe);
            m_temp <= tx_load ? 1'b1 : (wr_tdata ? 1'b0 : m_temp);
            if (wr_ctrl) begin
                m_rie <= wr_rx_ie; m_tie <= wr_tx_ie; m_bie <= wr_idle_ie;
            end
            m_rxi <= m_rie & (m_full | m_fre | m_pe);
            m_txi <= m_tie & m_temp;
            m_idi <= m_bie & rx_idle & tx_idle & ~sync_mode;
        end
    end

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R1", "rx_full", rx_full, m_full);
        chk("R2", "err_frame", err_frame, m_fre);
        chk("R2", "err_parity", err_parity, m_pe);
        chk("R4", "tx_empty", tx_empty, m_temp);
        chk("R9", "data_valid", data_valid, m_full & ~m_fre & ~m_pe);
        chk("R6", "rx_irq", rx_irq, m_rxi);
        chk("R7", "tx_irq", tx_irq, m_txi);
        chk("R8", "idle_irq", idle_irq, m_idi);
    endtask

    task automatic quiet();
        soft_rst = 0; rx_done = 0; rx_stop_bit = 1; rx_parity_ok = 1; tx_load = 0;
        rd_rdata = 0; wr_tdata = 0; wr_ctrl = 0; wr_err_clr = 0;
    endtask

    // one clock: both model and design update, then compare at the falling edge
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare_all();
        quiet();
    endtask

    task automatic ctrl(input logic clr, input logic rie, input logic tie, input logic bie);
        wr_ctrl = 1; wr_err_clr = clr; wr_rx_ie = rie; wr_tx_ie = tie; wr_idle_ie = bie;
    endtask

    initial begin
        #400000;
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        // reset state
        chk("R4", "tx_empty at reset", tx_empty, 1'b1);
        chk("R1", "rx_full at reset", rx_full, 1'b0);
        chk("R7", "tx_irq at reset", tx_irq, 1'b0);
        rst_n = 1;
        tick();

        // R7 R11: enabling transmit irq with tx_empty=1 from reset fires it
        ctrl(0, 0, 1, 0); tick();
        tick();
        chk("R7", "tx_irq after enable", tx_irq, 1'b1);
        tick();
        chk("R11", "tx_irq held without ctrl write", tx_irq, 1'b1);

        // R4: write tx data clears, load sets
        wr_tdata = 1; tick(); tick();
        chk("R4", "tx_empty after write", tx_empty, 1'b0);
        tx_load = 1; tick(); tick();
        chk("R4", "tx_empty after load", tx_empty, 1'b1);

        // R1 R9: good frame
        rx_done = 1; tick();
        chk("R9", "data_valid good frame", data_valid, 1'b1);
        // R1: control write with error clear and tx accesses do not clear rx_full
        ctrl(1, 1, 1, 0); tick();
        wr_tdata = 1; tick();
        tx_load = 1; tick(); tick();
        chk("R1", "rx_full survives other accesses", rx_full, 1'b1);
        chk("R6", "rx_irq with full", rx_irq, 1'b1);
        rd_rdata = 1; tick(); tick();
        chk("R1", "rx_full after read", rx_full, 1'b0);
        chk("R6", "rx_irq after read", rx_irq, 1'b0);

        // R2: bad stop, then bad parity
        rx_done = 1; rx_stop_bit = 0; tick();
        chk("R2", "err_frame set", err_frame, 1'b1);
        chk("R9", "data_valid with frame error", data_valid, 1'b0);
        rd_rdata = 1; tick();
        rx_done = 1; rx_parity_ok = 0; tick();
        chk("R2", "err_parity set", err_parity, 1'b1);
        rd_rdata = 1; tick(); tick();
        chk("R6", "rx_irq from errors alone", rx_irq, 1'b1);

        // R3: clear takes effect two edges after the write
        ctrl(1, 1, 1, 0); tick();
        chk("R3", "err_frame one edge after clear write", err_frame, 1'b1);
        tick();
        chk("R3", "err_frame cleared", err_frame, 1'b0);
        chk("R3", "err_parity cleared", err_parity, 1'b0);
        // R3: pulse lasts one cycle only
        rx_done = 1; rx_stop_bit = 0; tick(); tick();
        chk("R3", "error survives after pulse ended", err_frame, 1'b1);

        // R5: set beats clear on every flag
        rd_rdata = 1; rx_done = 1; tick();
        chk("R5", "rx_full set wins", rx_full, 1'b1);
        wr_tdata = 1; tx_load = 1; tick();
        chk("R5", "tx_empty set wins", tx_empty, 1'b1);
        ctrl(1, 1, 1, 0); tick();
        rx_done = 1; rx_stop_bit = 0; rx_parity_ok = 0; tick();
        chk("R5", "err_frame set wins over pulse", err_frame, 1'b1);
        chk("R5", "err_parity set wins over pulse", err_parity, 1'b1);

        // R8: idle combinations
        ctrl(0, 0, 0, 1); tick();
        for (int i = 0; i < 4; i++) begin
            rx_idle = i[0]; tx_idle = i[1];
            tick(); tick();
            chk("R8", "idle combo", idle_irq, (i == 3) ? 1'b1 : 1'b0);
        end
        sync_mode = 1; tick(); tick();
        chk("R8", "idle forced off in sync mode", idle_irq, 1'b0);
        sync_mode = 0; tick(); tick();
        chk("R8", "idle back after sync mode", idle_irq, 1'b1);

        // R10: soft reset from busy state
        ctrl(0, 1, 1, 1); tick();
        wr_tdata = 1; rx_done = 1; tick(); tick();
        soft_rst = 1; rx_done = 1; tick();
        chk("R10", "tx_empty after soft reset", tx_empty, 1'b1);
        chk("R10", "rx_full after soft reset", rx_full, 1'b0);
        chk("R10", "idle_irq after soft reset", idle_irq, 1'b0);
        tick(); tick();
        chk("R10", "enables zeroed by soft reset", idle_irq, 1'b0);

        // hardware reset mid run
        wr_tdata = 1; tick();
        rst_n = 0; #1;
        chk("R4", "tx_empty on hard reset", tx_empty, 1'b1);
        @(negedge clk); rst_n = 1; tick();

        for (int k = 0; k < 40; k++) begin
            rx_done = k[0]; rx_stop_bit = ~k[2]; rx_parity_ok = ~k[3];
            rd_rdata = k[1]; wr_tdata = k[2]; tx_load = k[4];
            if (k % 5 == 0) ctrl(k[1], k[2], k[3], 1);
            tick();
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule